// File: doc/BRIEF.md
# SPI Master with Live FIFO Status

This block is a memory-mapped SPI master. Software pushes bytes into a transmit FIFO through a data port. The shift engine sends each byte out on `mosi` in SPI mode 0, most significant bit first, and captures one byte from `miso` into a receive FIFO for every byte it sends. Software pops received bytes through the same data port. A control/status register combines the stored control bits with status flags. The flags are computed from the FIFO levels on every cycle, so they are never stale copies.

The control word holds the transfer-active enable, two FIFO clear strobes and two interrupt enables. One interrupt enable fires when the transfer has drained. The other fires when the receive FIFO reaches its three-quarter watermark. A single level interrupt combines the two sources. Alongside the control word sit a clock divider, a length register, a hold register and a DMA-control register. The shift engine uses only the divider. The other three are plain storage with fixed widths and reset values.

The register map uses word offsets: control/status 0x00, data port 0x04, divider 0x08, length 0x0C, hold 0x10, DMA control 0x14.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control/status reads 0x0004_1000 (bit 12 enable set, transmit-space flag set), the divider reads 0, the length reads 0, the hold register reads 1 and the DMA-control register reads 0x3020_1020.
- R2: The receive-present flag (bit 17) is 1 exactly when the receive FIFO is non-empty. The receive-full flag (bit 20) is 1 exactly when it holds FIFO_DEPTH bytes.
- R3: The watermark flag (bit 19) is 1 when transfer-active (bit 7) is set and the receive FIFO holds at least 3/4 of FIFO_DEPTH bytes. Writing control with bit 7 clear therefore drops it to 0.
- R4: The transmit-space flag (bit 18) is 1 while the transmit FIFO is not full. The done flag (bit 16) is 1 only when bit 7 is set, the transmit FIFO is empty and no byte is in flight.
- R5: `irq` is high exactly when (bit 9 and done) or (bit 10 and watermark) holds. It follows every control write and data access without a separate update step.
- R6: A control write stores bits 15:0 only. Status bits 20:16 keep their live values whatever is written. Clear strobes bits 4 (transmit) and 5 (receive) always read back 0.
- R7: Writing control with bit 4 or bit 5 set empties the transmit or receive FIFO, and the matching flags reflect this on the next cycle.
- R8: A data-port write is dropped while bit 7 is 0 or while the transmit FIFO is full. Otherwise bits 7:0 are pushed.
- R9: The engine starts a byte only when bit 7 is set, the transmit FIFO is non-empty and the receive FIFO is not full. Every byte sent pushes exactly one received byte, in order.
- R10: A data-port read of an empty receive FIFO returns 0 and changes no FIFO.
- R11: `sclk` idles low. Its period is the divider value rounded down to even, in system clocks (0 or 1 means 65536). `miso` is sampled on the rising edge, MSB first.
- R12: The divider and length registers store 16 bits and the hold register 4 bits. Offsets above 0x14 read 0 and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with FIFO_DEPTH = 8, which puts the watermark at six bytes. A receive-full stall then takes only eight bytes, and a transmit-full drop only nine. With this depth, both overflow boundaries and the transition from five to six bytes on the watermark can be reached in a few thousand cycles. Divider values of 2, 7 and 40 exercise the fastest clock, rounding of an odd divider and a slow engine. The slow engine lets the bench fill the transmit FIFO while a byte is still shifting.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int PTR_W   = $clog2(FIFO_DEPTH);
  localparam int CNT_W   = PTR_W + 1;
  localparam int IDX_W   = ADDR_W - 2;
  localparam int RXR_LVL = (FIFO_DEPTH * 3) / 4;
  localparam int B_CLR_TX = 4, B_CLR_RX = 5, B_TA = 7, B_INTD = 9, B_INTR = 10;

  logic [15:0] ctrl_q, div_q, len_q;
  logic [3:0]  hold_q;
  logic [31:0] dmac_q;

  logic [7:0]       tx_mem [FIFO_DEPTH];
  logic [7:0]       rx_mem [FIFO_DEPTH];
  logic [PTR_W-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;

  logic        busy, sclk_q;
  logic [2:0]  bit_idx;
  logic [15:0] hcnt, half_max;
  logic [7:0]  tx_sh, rx_sh;

  wire [IDX_W-1:0] idx = bus_addr[ADDR_W-1:2];
  wire aligned  = (bus_addr[1:0] == 2'b00);
  wire wr_ctrl  = bus_sel & bus_wr & aligned & (idx == IDX_W'(0));
  wire wr_fifo  = bus_sel & bus_wr & aligned & (idx == IDX_W'(1));
  wire rd_fifo  = bus_sel & ~bus_wr & aligned & (idx == IDX_W'(1));
  wire ta       = ctrl_q[B_TA];

  wire tx_full  = (tx_cnt == CNT_W'(FIFO_DEPTH));
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == CNT_W'(FIFO_DEPTH));
  wire rx_empty = (rx_cnt == '0);
  wire fl_done  = ta & tx_empty & ~busy;
  wire fl_rxr   = ta & (rx_cnt >= CNT_W'(RXR_LVL));

  wire clr_tx   = wr_ctrl & bus_wdata[B_CLR_TX];
  wire clr_rx   = wr_ctrl & bus_wdata[B_CLR_RX];
  wire tx_push  = wr_fifo & ta & ~tx_full;
  wire start    = ~busy & ta & ~tx_empty & ~rx_full & ~clr_tx;
  wire tick     = (hcnt >= half_max);
  wire byte_end = busy & tick & sclk_q & (bit_idx == 3'd7);
  wire rx_pop   = rd_fifo & ~rx_empty;

  assign half_max = (div_q[15:1] == 15'd0) ? 16'h7FFF : {1'b0, div_q[15:1]} - 16'd1;
  assign irq  = (ctrl_q[B_INTD] & fl_done) | (ctrl_q[B_INTR] & fl_rxr);
  assign sclk = sclk_q;
  assign mosi = tx_sh[7];

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        IDX_W'(0): bus_rdata = {11'd0, rx_full, fl_rxr, ~tx_full, ~rx_empty, fl_done, ctrl_q};
        IDX_W'(1): bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_mem[rx_rp]};
        IDX_W'(2): bus_rdata = {16'd0, div_q};
        IDX_W'(3): bus_rdata = {16'd0, len_q};
        IDX_W'(4): bus_rdata = {28'd0, hold_q};
        IDX_W'(5): bus_rdata = dmac_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 16'h1000;
      div_q  <= '0;
      len_q  <= '0;
      hold_q <= 4'h1;
      dmac_q <= 32'h3020_1020;
    end else if (bus_sel && bus_wr && aligned) begin
      case (idx)
        IDX_W'(0): ctrl_q <= bus_wdata[15:0] & ~(16'(1) << B_CLR_TX) & ~(16'(1) << B_CLR_RX);
        IDX_W'(2): div_q  <= bus_wdata[15:0];
        IDX_W'(3): len_q  <= bus_wdata[15:0];
        IDX_W'(4): hold_q <= bus_wdata[3:0];
        IDX_W'(5): dmac_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push && !clr_tx) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (byte_end && !clr_rx) rx_mem[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (clr_tx) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (start)   tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + CNT_W'(tx_push) - CNT_W'(start);
      end
      if (clr_rx) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (byte_end) rx_wp <= rx_wp + 1'b1;
        if (rx_pop)   rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + CNT_W'(byte_end) - CNT_W'(rx_pop);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk_q <= 1'b0; bit_idx <= '0;
      hcnt <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; sclk_q <= 1'b0; bit_idx <= '0;
        hcnt <= '0; tx_sh <= tx_mem[tx_rp];
      end
    end else if (tick) begin
      hcnt <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_sh  <= {rx_sh[6:0], miso};
      end else begin
        sclk_q <= 1'b0;
        if (bit_idx == 3'd7) busy <= 1'b0;
        else begin
          bit_idx <= bit_idx + 3'd1;
          tx_sh   <= {tx_sh[6:0], 1'b0};
        end
      end
    end else begin
      hcnt <= hcnt + 16'd1;
    end
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 5,
  parameter int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              sclk,
  input logic              busy,
  input logic [15:0]       ctrl_q,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt
);
  wire fifo_acc = bus_sel && (bus_addr == ADDR_W'(4));

  // R2
  rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(FIFO_DEPTH));

  // R8
  tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(FIFO_DEPTH));

  // R8
  idle_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_acc && bus_wr && !ctrl_q[7]) |=> (tx_cnt == $past(tx_cnt)));

  // R9
  start_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(rx_cnt) != CNT_W'(FIFO_DEPTH)));

  // R10
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_acc && !bus_wr && rx_cnt == '0) |-> (bus_rdata == 32'd0));

  // R11
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[9] && !ctrl_q[10]) |-> !irq);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk), .busy(busy), .ctrl_q(ctrl_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_fifo_master_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_master_tb_top;
  localparam int DEPTH = 8;
  localparam logic [4:0] A_CTRL = 5'h00, A_FIFO = 5'h04, A_DIV = 5'h08,
                         A_LEN = 5'h0C, A_HOLD = 5'h10, A_DMAC = 5'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, sclk, mosi, miso;

  int tests = 0, fails = 0;
  int cyc = 0, last_rise = 0, prev_rise = 0;
  logic [7:0] mon_sh = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign miso = ~mosi;
  always @(posedge sclk) begin
    mon_sh    <= {mon_sh[6:0], mosi};
    prev_rise <= last_rise;
    last_rise <= cyc;
  end

  spi_fifo_master #(.FIFO_DEPTH(DEPTH), .ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0004_1000);
    rd(A_DIV, d);  check("R1 div", d, 0);
    rd(A_LEN, d);  check("R1 len", d, 0);
    rd(A_HOLD, d); check("R1 hold", d, 1);
    rd(A_DMAC, d); check("R1 dmac", d, 32'h3020_1020);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_DIV, 32'h0001_2345); rd(A_DIV, d); check("R12 div width", d, 32'h2345);
    wr(A_LEN, 32'hFFFF_ABCD); rd(A_LEN, d); check("R12 len width", d, 32'hABCD);
    wr(A_HOLD, 32'hFF);       rd(A_HOLD, d); check("R12 hold width", d, 32'hF);
    wr(5'h18, 32'hDEAD_BEEF); rd(5'h18, d); check("R12 unmapped", d, 0);
    rd(A_DMAC, d); check("R12 dmac untouched", d, 32'h3020_1020);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(A_DIV, 2);
    wr(A_FIFO, 32'hAA);
    wr(A_CTRL, 32'h1080);
    idle(40);
    rd(A_CTRL, d); check("R8 write with TA=0 dropped", d, 32'h0005_1080);
    rd(A_FIFO, d); check("R10 empty read", d, 0);
    rd(A_CTRL, d); check("R10 fifos unchanged", d, 32'h0005_1080);
  endtask

  task automatic t_xfer();
    logic [31:0] d;
    wr(A_FIFO, 32'h3C);
    idle(40);
    rd(A_CTRL, d); check("R2 R4 flags after byte", d, 32'h0007_1080);
    check("R11 mosi MSB first", {24'd0, mon_sh}, 32'h3C);
    rd(A_FIFO, d); check("R9 received byte", d, 32'hC3);
    check("R11 sclk idle low", {31'd0, sclk}, 0);
  endtask

  task automatic t_sclk();
    logic [31:0] d;
    wr(A_DIV, 7);
    wr(A_FIFO, 32'h81);
    idle(80);
    check("R11 period odd divider", last_rise - prev_rise, 6);
    rd(A_FIFO, d); check("R9 second pattern", d, 32'h7E);
    wr(A_DIV, 2);
  endtask

  task automatic t_ro_bits();
    logic [31:0] d;
    wr(A_CTRL, 32'h001F_00B0);
    rd(A_CTRL, d); check("R6 status kept, strobes read 0", d, 32'h0005_0080);
  endtask

  task automatic t_done_irq();
    logic [31:0] d;
    wr(A_CTRL, 32'h0280); idle(2);
    check("R5 irq on done", {31'd0, irq}, 1);
    wr(A_CTRL, 32'h0080); idle(2);
    check("R5 irq masked", {31'd0, irq}, 0);
    wr(A_CTRL, 32'h0200);
    rd(A_CTRL, d); check("R4 done needs TA", d, 32'h0004_0200);
    check("R5 irq off without TA", {31'd0, irq}, 0);
  endtask

  task automatic t_watermark();
    logic [31:0] d;
    wr(A_CTRL, 32'h04B0);
    for (int i = 0; i < 5; i++) wr(A_FIFO, 32'h10 + i);
    idle(150);
    rd(A_CTRL, d); check("R3 below watermark", d & 32'h0008_0000, 0);
    check("R5 irq low below watermark", {31'd0, irq}, 0);
    wr(A_FIFO, 32'h15);
    idle(40);
    rd(A_CTRL, d); check("R3 at watermark", d & 32'h0008_0000, 32'h0008_0000);
    check("R5 irq on watermark", {31'd0, irq}, 1);
    wr(A_CTRL, 32'h0400);
    rd(A_CTRL, d); check("R3 TA clear drops watermark", d, 32'h0006_0400);
    check("R5 irq follows", {31'd0, irq}, 0);
    wr(A_CTRL, 32'h0420);
    rd(A_CTRL, d); check("R7 rx clear", d, 32'h0004_0400);
  endtask

  task automatic t_stall();
    logic [31:0] d;
    logic [7:0] b [10];
    for (int i = 0; i < 10; i++) b[i] = 8'(8'hA0 + i * 7);
    wr(A_DIV, 40);
    wr(A_CTRL, 32'h04B0);
    for (int i = 0; i < 10; i++) wr(A_FIFO, {24'd0, b[i]});
    rd(A_CTRL, d); check("R4 tx full clears space flag", d & 32'h0004_0000, 0);
    wr(A_DIV, 2);
    idle(500);
    rd(A_CTRL, d); check("R2 R9 rx full stalls engine", d, 32'h001E_0480);
    check("R5 irq with rx full", {31'd0, irq}, 1);
    for (int i = 0; i < 8; i++) begin
      rd(A_FIFO, d); check("R9 order", d, {24'd0, ~b[i]});
    end
    idle(40);
    rd(A_FIFO, d); check("R9 stalled byte resumes", d, {24'd0, ~b[8]});
    rd(A_FIFO, d); check("R8 byte into full fifo dropped", d, 0);
  endtask

  task automatic t_clear_tx();
    logic [31:0] d;
    wr(A_DIV, 40);
    wr(A_CTRL, 32'h00B0);
    wr(A_FIFO, 32'h11); wr(A_FIFO, 32'h22); wr(A_FIFO, 32'h33);
    wr(A_CTRL, 32'h0090);
    rd(A_CTRL, d); check("R7 tx cleared, byte in flight", d, 32'h0004_0080);
    idle(400);
    rd(A_CTRL, d); check("R4 done after flight", d, 32'h0007_0080);
    rd(A_FIFO, d); check("R7 only in-flight byte", d, 32'hEE);
    rd(A_FIFO, d); check("R7 nothing more", d, 0);
    wr(A_DIV, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_ignore();
    t_xfer();
    t_sclk();
    t_ro_bits();
    t_done_irq();
    t_watermark();
    t_stall();
    t_clear_tx();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule